// File: doc/BRIEF.md
# Single-Cycle Six-Instruction RISC Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It supports register add, add-immediate, word load, word store, branch-if-equal and absolute jump, plus a jump that saves its return address and a jump to an address held in a register. The core holds the program counter, a 32-entry register file, an arithmetic unit that adds or subtracts, and word-addressed instruction and data memories. All three kinds of state (PC, registers, data words) change together on the rising clock edge, and every read in a cycle sees the state from before that edge.

A decoder turns the opcode, and for register-format words the function field, into one of nine instruction kinds (add, add-immediate, load, store, branch, jump, jump-and-link, register jump, no-op). A second stage maps the kind onto ten control flags: eight datapath flags (branch, jump, immediate second operand, subtract, store enable, register write, destination from the rd field, write-back from memory) and two extension flags (link and register jump). Any opcode or function code not listed decodes to the no-op kind. There is no state machine: the only sequential state is the PC, the register file and the data memory. While reset is held, a loading port fills the instruction memory. Each cycle the core shows its PC and the register write or memory store that the current instruction will commit.

Top module: `sc_core`

## Requirements
- R1: While reset is low, the PC is 0, every register reads 0 and every data-memory word is 0. Execution starts at address 0 in the first cycle after reset.
- R2: An instruction that is not a taken branch or a jump sets the next PC to PC+4.
- R3: Format fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and func[5:0]. add (op 0x00, func 0x20) writes rs+rt, modulo 2^32, into register rd.
- R4: addi (op 0x08) writes rs plus the sign-extended imm[15:0] into register rt.
- R5: lw (op 0x23) writes into rt the data word at byte address rs+sext(imm). A load in the cycle after a store to the same address returns the stored value.
- R6: sw (op 0x2B) writes register rt to the data word at byte address rs+sext(imm), and it writes no register.
- R7: beq (op 0x04) sets the next PC to PC+4+(sext(imm)<<2) when rs equals rt, and to PC+4 otherwise. It writes neither register nor memory.
- R8: j (op 0x02) sets the next PC to {PC+4[31:28], imm[25:0], 2'b00} and writes nothing.
- R9: jal (op 0x03) jumps like j and writes PC+4 into register 31.
- R10: jr (op 0x00, func 0x08) sets the next PC to the value of register rs and writes nothing.
- R11: Register 0 always reads 0. A write to it has no effect and is not reported on wb_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Instruction-memory load strobe |
| prog_addr | input | 6 | Word index to load |
| prog_data | input | 32 | Instruction word to load |
| pc_out | output | 32 | Current PC |
| wb_en | output | 1 | The current instruction writes a register (never register 0) |
| wb_addr | output | 5 | Destination register |
| wb_data | output | 32 | Register write data |
| st_en | output | 1 | The current instruction stores a data word |
| st_addr | output | 32 | Store byte address |
| st_data | output | 32 | Store data |

## Verification
The hardest cases to reach from the ports involve state that depends on earlier cycles. One is a load that must return a word stored in the previous cycle. Another is a register jump whose target comes from a link value written several instructions earlier. The stimulus is a short loaded program that stores and then loads at once, calls a subroutine with jal, uses the link register both as a base address with a negative offset and as the jr target, and takes a branch whose operands came from that load. The program also writes register 0 and then reads it, takes one branch and falls through another, and finally parks in a backward branch to itself. Each cycle the scoreboard compares the PC and the committed register write or store with the value predicted for that instruction.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN    = 32;
    localparam int REG_AW  = 5;
    localparam int LINK_RG = 31;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_JAL   = 6'h03;
    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] FN_JR    = 6'h08;

    typedef enum logic [3:0] {
        K_NOP, K_ADD, K_ADDI, K_LW, K_SW, K_BEQ, K_J, K_JAL, K_JR
    } insn_kind_e;

    typedef struct packed {
        logic br;
        logic jp;
        logic alu_inb;
        logic alu_sub;
        logic dm_we;
        logic rwe;
        logic rdst;
        logic rwd;
        logic link;
        logic jreg;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] func,
    output ctrl_t      ctrl
);

    insn_kind_e kind;

    always_comb begin
        unique case (op)
            OP_RTYPE: begin
                if (func == FN_ADD)     kind = K_ADD;
                else if (func == FN_JR) kind = K_JR;
                else                    kind = K_NOP;
            end
            OP_ADDI: kind = K_ADDI;
            OP_LW:   kind = K_LW;
            OP_SW:   kind = K_SW;
            OP_BEQ:  kind = K_BEQ;
            OP_J:    kind = K_J;
            OP_JAL:  kind = K_JAL;
            default: kind = K_NOP;
        endcase
    end

    always_comb begin
        ctrl = '0;
        unique case (kind)
            K_ADD:  begin ctrl.rwe = 1'b1; ctrl.rdst = 1'b1; end
            K_ADDI: begin ctrl.alu_inb = 1'b1; ctrl.rwe = 1'b1; end
            K_LW:   begin ctrl.alu_inb = 1'b1; ctrl.rwe = 1'b1; ctrl.rwd = 1'b1; end
            K_SW:   begin ctrl.alu_inb = 1'b1; ctrl.dm_we = 1'b1; end
            K_BEQ:  begin ctrl.br = 1'b1; ctrl.alu_sub = 1'b1; end
            K_J:    begin ctrl.jp = 1'b1; end
            K_JAL:  begin ctrl.jp = 1'b1; ctrl.rwe = 1'b1; ctrl.link = 1'b1; end
            K_JR:   begin ctrl.jreg = 1'b1; end
            K_NOP:  begin end
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        y    = sub ? (a - b) : (a + b);
        zero = (y == '0);
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    // R11: the value of register 0 stays zero after any write to it
    a_r11_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa == '0) |=> (regs[0] == '0));

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prog_we,
    input  logic [IAW-1:0]  prog_addr,
    input  logic [XLEN-1:0] prog_data,
    output logic [XLEN-1:0] pc_out,
    output logic            wb_en,
    output logic [4:0]      wb_addr,
    output logic [XLEN-1:0] wb_data,
    output logic            st_en,
    output logic [XLEN-1:0] st_addr,
    output logic [XLEN-1:0] st_data
);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];
    logic [XLEN-1:0] pc_q, pc_nx, pc4, br_tgt, jp_tgt;
    logic [XLEN-1:0] instr, simm, rs_val, rt_val, alu_b, alu_y, dm_rd, wd;
    logic [REG_AW-1:0] dest;
    logic            alu_zero;
    ctrl_t           c;

    // instruction memory: loaded through the program port
    always_ff @(posedge clk) begin
        if (prog_we) imem[prog_addr] <= prog_data;
    end

    assign instr = imem[pc_q[IAW+1:2]];
    assign simm  = {{16{instr[15]}}, instr[15:0]};

    sc_decode u_dec (
        .op   (instr[31:26]),
        .func (instr[5:0]),
        .ctrl (c)
    );

    sc_regfile #(.NREGS(32), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (instr[25:21]),
        .ra2   (instr[20:16]),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .we    (c.rwe),
        .wa    (dest),
        .wd    (wd)
    );

    assign alu_b = c.alu_inb ? simm : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .sub  (c.alu_sub),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory: combinational read, write on the edge
    assign dm_rd = dmem[alu_y[DAW+1:2]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
        end else if (c.dm_we) begin
            dmem[alu_y[DAW+1:2]] <= rt_val;
        end
    end

    // write-back selection
    always_comb begin
        if (c.link)      dest = REG_AW'(LINK_RG);
        else if (c.rdst) dest = instr[15:11];
        else             dest = instr[20:16];
        if (c.link)      wd = pc4;
        else if (c.rwd)  wd = dm_rd;
        else             wd = alu_y;
    end

    // next-PC selection
    assign pc4    = pc_q + 32'd4;
    assign br_tgt = pc4 + {simm[29:0], 2'b00};
    assign jp_tgt = {pc4[31:28], instr[25:0], 2'b00};

    always_comb begin
        if (c.jreg)                pc_nx = rs_val;
        else if (c.jp)             pc_nx = jp_tgt;
        else if (c.br && alu_zero) pc_nx = br_tgt;
        else                       pc_nx = pc4;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_nx;
    end

    assign pc_out  = pc_q;
    assign wb_en   = c.rwe && (dest != '0);
    assign wb_addr = dest;
    assign wb_data = wd;
    assign st_en   = c.dm_we;
    assign st_addr = alu_y;
    assign st_data = rt_val;

    // R2: sequential flow advances by one word
    a_r2_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (!c.br && !c.jp && !c.jreg) |=> (pc_q == $past(pc_q) + 32'd4));

    // R7: equal operands redirect to the offset target
    a_r7_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (c.br && rs_val == rt_val) |=>
        (pc_q == $past(pc_q) + 32'd4 + ($past(simm) << 2)));

    // R7: unequal operands fall through
    a_r7_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (c.br && rs_val != rt_val) |=> (pc_q == $past(pc_q) + 32'd4));

    // R6: a store never reports a register write
    a_r6_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |-> !wb_en);

    // R10: a register jump lands on the register value
    a_r10_jr_target: assert property (@(posedge clk) disable iff (!rst_n)
        c.jreg |=> (pc_q == $past(rs_val)));

    // R11: register 0 is never reported as written
    a_r11_no_r0_wb: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_addr != '0));

endmodule

// File: tb/sc_core_test.sv
module sc_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic [31:0] pc_out, wb_data, st_addr, st_data;
    logic [4:0]  wb_addr;
    logic        wb_en, st_en;

    sc_core uut (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .pc_out(pc_out), .wb_en(wb_en), .wb_addr(wb_addr),
        .wb_data(wb_data), .st_en(st_en), .st_addr(st_addr), .st_data(st_data)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [31:0] pc;
        logic        wb;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        st;
        logic [31:0] sa;
        logic [31:0] sd;
        string       tag;
    } exp_t;

    exp_t        sb [$];
    logic [31:0] prog [64];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    bit          reported = 1'b0;

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_j(logic [5:0] op, int idx);
        return {op, 26'(idx)};
    endfunction

    task automatic push_exp(logic [31:0] pc, logic wb, int wa, logic [31:0] wd,
                            logic st, logic [31:0] sa, logic [31:0] sd, string tag);
        exp_t e;
        e.pc = pc; e.wb = wb; e.wa = 5'(wa); e.wd = wd;
        e.st = st; e.sa = sa; e.sd = sd; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic miss(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_bad++;
        $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    endtask

    task automatic report;
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // driver: program and expected commit stream
    initial begin
        for (int i = 0; i < 64; i++) prog[i] = 32'h0;
        prog[0]  = enc_i(6'h08, 0, 1, 5);            // addi r1,r0,5
        prog[1]  = enc_i(6'h08, 0, 2, -3);           // addi r2,r0,-3
        prog[2]  = enc_r(1, 2, 3, 6'h20);            // add r3,r1,r2
        prog[3]  = enc_i(6'h2B, 0, 3, 8);            // sw r3,8(r0)
        prog[4]  = enc_i(6'h23, 0, 4, 8);            // lw r4,8(r0)
        prog[5]  = enc_i(6'h08, 0, 0, 7);            // addi r0,r0,7
        prog[6]  = enc_r(0, 1, 5, 6'h20);            // add r5,r0,r1
        prog[7]  = enc_i(6'h04, 3, 4, 2);            // beq r3,r4,+2
        prog[8]  = enc_i(6'h08, 0, 6, 1);            // skipped
        prog[9]  = enc_i(6'h08, 0, 6, 2);            // skipped
        prog[10] = enc_i(6'h04, 1, 3, 5);            // beq r1,r3 (not taken)
        prog[11] = enc_j(6'h03, 16);                 // jal 64
        prog[12] = enc_i(6'h08, 0, 7, 9);            // addi r7,r0,9
        prog[13] = enc_i(6'h23, 0, 8, 12);           // lw r8,12(r0)
        prog[14] = enc_j(6'h02, 20);                 // j 80
        prog[16] = enc_i(6'h2B, 31, 5, -4);          // sw r5,-4(r31)
        prog[17] = enc_r(31, 0, 0, 6'h08);           // jr r31
        prog[20] = enc_i(6'h04, 0, 0, -1);           // beq r0,r0,-1

        push_exp(0,  1, 1,  32'd5,        0, 0, 0, "R1 R4");
        push_exp(4,  1, 2,  32'hFFFFFFFD, 0, 0, 0, "R2 R4");
        push_exp(8,  1, 3,  32'd2,        0, 0, 0, "R3");
        push_exp(12, 0, 0,  0,            1, 32'd8, 32'd2, "R6");
        push_exp(16, 1, 4,  32'd2,        0, 0, 0, "R5");
        push_exp(20, 0, 0,  0,            0, 0, 0, "R11");
        push_exp(24, 1, 5,  32'd5,        0, 0, 0, "R11");
        push_exp(28, 0, 0,  0,            0, 0, 0, "R7");
        push_exp(40, 0, 0,  0,            0, 0, 0, "R7");
        push_exp(44, 1, 31, 32'd48,       0, 0, 0, "R9");
        push_exp(64, 0, 0,  0,            1, 32'd44, 32'd5, "R6 R9");
        push_exp(68, 0, 0,  0,            0, 0, 0, "R10");
        push_exp(48, 1, 7,  32'd9,        0, 0, 0, "R10");
        push_exp(52, 1, 8,  32'd0,        0, 0, 0, "R1 R5");
        push_exp(56, 0, 0,  0,            0, 0, 0, "R8");
        push_exp(80, 0, 0,  0,            0, 0, 0, "R8");
        push_exp(80, 0, 0,  0,            0, 0, 0, "R7");
        push_exp(80, 0, 0,  0,            0, 0, 0, "R7");

        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            prog_we   = 1'b1;
            prog_addr = 6'(i);
            prog_data = prog[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
        #2;
        n_vec++;
        if (pc_out !== 32'd0) miss("R1", "pc in reset", pc_out, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    end

    // monitor: pop and compare once per cycle, away from the clock edge
    initial begin
        exp_t e;
        @(posedge rst_n);
        while (sb.size() > 0) begin
            #2;
            e = sb.pop_front();
            n_vec++;
            if (pc_out !== e.pc) miss(e.tag, "pc", pc_out, e.pc);
            if (wb_en !== e.wb) miss(e.tag, "wb_en", 32'(wb_en), 32'(e.wb));
            else if (e.wb) begin
                if (wb_addr !== e.wa) miss(e.tag, "wb_addr", 32'(wb_addr), 32'(e.wa));
                if (wb_data !== e.wd) miss(e.tag, "wb_data", wb_data, e.wd);
            end
            if (st_en !== e.st) miss(e.tag, "st_en", 32'(st_en), 32'(e.st));
            else if (e.st) begin
                if (st_addr !== e.sa) miss(e.tag, "st_addr", st_addr, e.sa);
                if (st_data !== e.sd) miss(e.tag, "st_data", st_data, e.sd);
            end
            @(negedge clk);
        end
        done = 1'b1;
        report();
    end

    // watchdog
    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d items pending expected 0", sb.size());
        end
        report();
    end

endmodule